// File: doc/BRIEF.md
# Fractional Multiply-Accumulate with Product Rounding

This block multiplies two 32-bit signed fractional operands (values in the range -1.0 up to just under +1.0) and either adds the product to a 48-bit accumulator or subtracts it. The full 64-bit product first gets one left shift, which removes the duplicated sign bit that a signed fractional multiply produces. It is then cut to its 40 most significant bits before it reaches the accumulator.

A mode input chooses how that cut is made. One setting drops the 24 low bits (truncation). The other rounds them to the nearest value, and an exact half goes to the even neighbour. The single product that cannot be represented, -1.0 times -1.0, is clamped to the largest positive 40-bit value.

A caller presents the operands, the add/subtract select and the mode bits together with a one-cycle start strobe. The accumulator takes the new value on that clock edge, and a completion flag is high for the following cycle. Only fractional operation is handled: a start that arrives while the fractional-mode input is low is dropped.

Top module: `frac_mac`

## Requirements
- R1: The signed 64-bit product of `op_a` and `op_b` is shifted left by one bit, and the reduced product is formed from bits [63:24] of that shifted value.
- R2: With `round_en` = 0, the 24 discarded bits are dropped and the reduced product equals bits [63:24] unchanged (truncation toward minus infinity).
- R3: With `round_en` = 1, the reduced product is incremented when the discarded 24 bits exceed 0x800000, and it is left unchanged when they are below 0x800000.
- R4: With `round_en` = 1 and discarded bits exactly 0x800000, the reduced product is incremented only when its bit 0 is 1, so the result is always even.
- R5: With `sub_sel` = 0, the reduced product is sign-extended from 40 to 48 bits and added to the accumulator, modulo 2^48.
- R6: With `sub_sel` = 1, the same sign-extended reduced product is subtracted from the accumulator, modulo 2^48.
- R7: When both operands are 0x80000000 (-1.0), the reduced product is 0x7FFFFFFFFF in both rounding modes.
- R8: A start sampled high with `frac_mode` = 1 at a rising edge updates `acc_q` at that edge and sets `done` high for exactly the following cycle. Starts on consecutive edges each accumulate, and `done` stays high through them.
- R9: A start sampled while `frac_mode` = 0 leaves `acc_q` unchanged and does not raise `done`.
- R10: While reset is asserted, and after it is released, `acc_q` is zero and `done` is low until the first accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a | input | 32 | First fractional operand, two's complement |
| op_b | input | 32 | Second fractional operand, two's complement |
| sub_sel | input | 1 | 0 adds the reduced product, 1 subtracts it |
| frac_mode | input | 1 | Must be 1 for a start to be accepted |
| round_en | input | 1 | 0 truncates, 1 rounds to nearest even |
| start | input | 1 | One-cycle request to perform an operation |
| acc_q | output | 48 | Accumulator value |
| done | output | 1 | High for the cycle after an accepted start |

## Verification
The rounding increment and the subtract path can act in the same cycle. A rounded-up product then has to be negated after the carry, not before it. The bench provokes this by subtracting a product whose discarded bits are above half and one whose discarded bits are an odd tie. It then compares the accumulator with a value worked out by hand. A second overlap, a new start in the cycle where `done` is still high from the previous one, is driven back to back: the bench expects two accumulations and an unbroken `done`.

// File: rtl/frac_mac_pkg.sv
package frac_mac_pkg;
  localparam int unsigned OPND_W = 32;
  localparam int unsigned ACCM_W = 48;
  localparam int unsigned RED_W  = 40;

  typedef enum logic {
    ACC_ADD = 1'b0,
    ACC_SUB = 1'b1
  } acc_dir_e;
endpackage

// File: rtl/frac_mac_rst_sync.sv
module frac_mac_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/frac_mac_mul.sv
module frac_mac_mul #(
  parameter int unsigned OP_W = 32,
  localparam int unsigned PROD_W = 2 * OP_W
) (
  input  logic [OP_W-1:0]   mul_a,
  input  logic [OP_W-1:0]   mul_b,
  output logic [PROD_W-1:0] prod_aligned,
  output logic              prod_clamp
);
  localparam logic [OP_W-1:0] MOST_NEG = {1'b1, {(OP_W-1){1'b0}}};

  logic signed [PROD_W-1:0] prod_raw;

  always_comb begin
    prod_raw     = $signed(mul_a) * $signed(mul_b);
    prod_aligned = {prod_raw[PROD_W-2:0], 1'b0};
    prod_clamp   = (mul_a == MOST_NEG) && (mul_b == MOST_NEG);
  end
endmodule

// File: rtl/frac_mac_reduce.sv
module frac_mac_reduce #(
  parameter int unsigned PROD_W = 64,
  parameter int unsigned KEEP_W = 40,
  localparam int unsigned DROP_W = PROD_W - KEEP_W
) (
  input  logic [PROD_W-1:0] prod_in,
  input  logic              clamp,
  input  logic              rnd_mode,
  output logic [KEEP_W-1:0] red_out
);
  localparam logic [DROP_W-1:0] HALF_LSB = {1'b1, {(DROP_W-1){1'b0}}};
  localparam logic [KEEP_W-1:0] POS_MAX  = {1'b0, {(KEEP_W-1){1'b1}}};

  logic [KEEP_W-1:0] upper;
  logic [DROP_W-1:0] lower;
  logic              above_half;
  logic              at_half;
  logic              bump;

  always_comb begin
    upper      = prod_in[PROD_W-1:DROP_W];
    lower      = prod_in[DROP_W-1:0];
    above_half = lower > HALF_LSB;
    at_half    = lower == HALF_LSB;
    bump       = rnd_mode && (above_half || (at_half && upper[0]));
    if (clamp) red_out = POS_MAX;
    else       red_out = upper + {{(KEEP_W-1){1'b0}}, bump};
  end
endmodule

// File: rtl/frac_mac_acc.sv
module frac_mac_acc #(
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned KEEP_W = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  frac_mac_pkg::acc_dir_e dir,
  input  logic [KEEP_W-1:0] addend,
  output logic [ACC_W-1:0]  acc_q,
  output logic              done_q
);
  localparam int unsigned EXT_W = ACC_W - KEEP_W;

  logic [ACC_W-1:0] addend_ext;
  logic [ACC_W-1:0] acc_d;
  logic             done_d;

  generate
    if (EXT_W > 0) begin : g_ext
      assign addend_ext = {{EXT_W{addend[KEEP_W-1]}}, addend};
    end else begin : g_noext
      assign addend_ext = addend[ACC_W-1:0];
    end
  endgenerate

  always_comb begin
    acc_d  = acc_q;
    done_d = acc_en;
    if (acc_en) begin
      if (dir == frac_mac_pkg::ACC_SUB) acc_d = acc_q - addend_ext;
      else                              acc_d = acc_q + addend_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= done_d;
      if (acc_en) acc_q <= acc_d;
    end
  end
endmodule

// File: rtl/frac_mac.sv
module frac_mac #(
  parameter int unsigned OP_W   = frac_mac_pkg::OPND_W,
  parameter int unsigned ACC_W  = frac_mac_pkg::ACCM_W,
  parameter int unsigned KEEP_W = frac_mac_pkg::RED_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic             sub_sel,
  input  logic             frac_mode,
  input  logic             round_en,
  input  logic             start,
  output logic [ACC_W-1:0] acc_q,
  output logic             done
);
  localparam int unsigned PROD_W = 2 * OP_W;

  logic              rst_core_n;
  logic [PROD_W-1:0] prod_aligned;
  logic              prod_clamp;
  logic [KEEP_W-1:0] prod_red;
  logic              accept;
  frac_mac_pkg::acc_dir_e dir;

  assign accept = start && frac_mode;
  assign dir    = sub_sel ? frac_mac_pkg::ACC_SUB : frac_mac_pkg::ACC_ADD;

  frac_mac_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_core_n)
  );

  frac_mac_mul #(.OP_W(OP_W)) u_mul (
    .mul_a        (op_a),
    .mul_b        (op_b),
    .prod_aligned (prod_aligned),
    .prod_clamp   (prod_clamp)
  );

  frac_mac_reduce #(.PROD_W(PROD_W), .KEEP_W(KEEP_W)) u_red (
    .prod_in  (prod_aligned),
    .clamp    (prod_clamp),
    .rnd_mode (round_en),
    .red_out  (prod_red)
  );

  frac_mac_acc #(.ACC_W(ACC_W), .KEEP_W(KEEP_W)) u_acc (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .acc_en (accept),
    .dir    (dir),
    .addend (prod_red),
    .acc_q  (acc_q),
    .done_q (done)
  );
endmodule

// File: rtl/frac_mac_chk.sv
module frac_mac_chk #(
  parameter int unsigned OP_W   = 32,
  parameter int unsigned ACC_W  = 48,
  parameter int unsigned KEEP_W = 40
) (
  input logic             clk,
  input logic             rst_n,
  input logic [OP_W-1:0]  op_a,
  input logic [OP_W-1:0]  op_b,
  input logic             sub_sel,
  input logic             frac_mode,
  input logic             round_en,
  input logic             start,
  input logic [ACC_W-1:0] acc_q,
  input logic             done
);
  localparam logic [OP_W-1:0]  NEG_ONE = {1'b1, {(OP_W-1){1'b0}}};
  localparam logic [ACC_W-1:0] SAT_EXT = {{(ACC_W-KEEP_W+1){1'b0}}, {(KEEP_W-1){1'b1}}};

  p_done_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start && frac_mode) |=> done);

  p_no_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && frac_mode) |=> !done);

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(start && frac_mode) |=> $stable(acc_q));

  p_zero_trunc_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && frac_mode && !round_en && (op_a == '0)) |=> $stable(acc_q));

  p_neg_one_sq_add_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (start && frac_mode && !sub_sel && op_a == NEG_ONE && op_b == NEG_ONE)
      |=> acc_q == $past(acc_q) + SAT_EXT);

  p_neg_one_sq_sub_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (start && frac_mode && sub_sel && op_a == NEG_ONE && op_b == NEG_ONE)
      |=> acc_q == $past(acc_q) - SAT_EXT);
endmodule

bind frac_mac frac_mac_chk #(.OP_W(OP_W), .ACC_W(ACC_W), .KEEP_W(KEEP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_core_n),
  .op_a      (op_a),
  .op_b      (op_b),
  .sub_sel   (sub_sel),
  .frac_mode (frac_mode),
  .round_en  (round_en),
  .start     (start),
  .acc_q     (acc_q),
  .done      (done)
);

// File: tb/frac_mac_bench.sv
module frac_mac_bench;
  logic        clk;
  logic        rst_n;
  logic [31:0] op_a;
  logic [31:0] op_b;
  logic        sub_sel;
  logic        frac_mode;
  logic        round_en;
  logic        start;
  logic [47:0] acc_q;
  logic        done;

  int checks;
  int fails;
  logic [47:0] model;

  frac_mac u_frac_mac (
    .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_sel(sub_sel),
    .frac_mode(frac_mode), .round_en(round_en), .start(start),
    .acc_q(acc_q), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // a, b, subtract, round, hand-computed reduced product (sign-extended), tag
  typedef struct packed {
    logic [31:0] a;
    logic [31:0] b;
    logic        sub;
    logic        rnd;
    logic [47:0] delta;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{32'h40000000, 32'h40000000, 1'b0, 1'b0, 48'h002000000000, 8'd1},  // R1 0.5*0.5
    '{32'h40000000, 32'hC0000000, 1'b0, 1'b1, 48'hFFE000000000, 8'd5},  // R5 negative product
    '{32'h00C00000, 32'h00000001, 1'b0, 1'b0, 48'h000000000001, 8'd2},  // R2 tie, truncated
    '{32'h00C00000, 32'h00000001, 1'b0, 1'b1, 48'h000000000002, 8'd4},  // R4 odd tie rounds up
    '{32'h00400000, 32'h00000001, 1'b0, 1'b1, 48'h000000000000, 8'd4},  // R4 even tie stays
    '{32'h00400001, 32'h00000001, 1'b0, 1'b1, 48'h000000000001, 8'd3},  // R3 above half
    '{32'h00400001, 32'h00000001, 1'b0, 1'b0, 48'h000000000000, 8'd2},  // R2 above half, cut
    '{32'h003FFFFF, 32'h00000001, 1'b0, 1'b1, 48'h000000000000, 8'd3},  // R3 below half
    '{32'hFFFFFFFF, 32'h00400000, 1'b0, 1'b1, 48'h000000000000, 8'd4},  // R4 negative odd tie
    '{32'hFFFFFFFF, 32'h00400000, 1'b0, 1'b0, 48'hFFFFFFFFFFFF, 8'd2},  // R2 floor of negative
    '{32'h80000000, 32'h80000000, 1'b0, 1'b0, 48'h007FFFFFFFFF, 8'd7},  // R7 clamp, trunc
    '{32'h80000000, 32'h80000000, 1'b1, 1'b1, 48'h007FFFFFFFFF, 8'd7},  // R7 clamp, sub
    '{32'h40000000, 32'h40000000, 1'b1, 1'b0, 48'h002000000000, 8'd6},  // R6 subtract
    '{32'h00400001, 32'h00000001, 1'b1, 1'b1, 48'h000000000001, 8'd6},  // R6 sub of rounded-up
    '{32'h00C00000, 32'h00000001, 1'b1, 1'b1, 48'h000000000002, 8'd6},  // R6 sub of odd tie
    '{32'hFFFFFFFF, 32'h00400000, 1'b1, 1'b0, 48'hFFFFFFFFFFFF, 8'd6}   // R6 sub of negative
  };

  task automatic check48(input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s acc_q actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s done actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] a, input logic [31:0] b,
                       input logic s, input logic r, input logic f);
    op_a = a; op_b = b; sub_sel = s; round_en = r; frac_mode = f; start = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    checks = 0; fails = 0; model = '0;
    rst_n = 1'b0; start = 1'b0; op_a = '0; op_b = '0;
    sub_sel = 1'b0; frac_mode = 1'b1; round_en = 1'b0;
    repeat (3) @(negedge clk);
    check48("R10 in reset", acc_q, 48'h0);
    check1("R10 in reset", done, 1'b0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check48("R10 after release", acc_q, 48'h0);
    check1("R10 after release", done, 1'b0);

    // table walk: one start, check on next negedge, then check done drops
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].a, VECS[i].b, VECS[i].sub, VECS[i].rnd, 1'b1);
      @(negedge clk);
      start = 1'b0;
      model = VECS[i].sub ? model - VECS[i].delta : model + VECS[i].delta;
      check48($sformatf("R%0d vec %0d", VECS[i].tag, i), acc_q, model);
      check1("R8 done after start", done, 1'b1);
      @(negedge clk);
      check1("R8 done one cycle", done, 1'b0);
      check48("R8 hold", acc_q, model);
    end

    // R9: start while not in fractional mode is dropped
    drive(32'h40000000, 32'h40000000, 1'b0, 1'b0, 1'b0);
    @(negedge clk);
    start = 1'b0; frac_mode = 1'b1;
    check48("R9 ignored start", acc_q, model);
    check1("R9 no done", done, 1'b0);

    // R8: back-to-back starts, both accumulate, done stays high
    drive(32'h40000000, 32'h40000000, 1'b0, 1'b1, 1'b1);
    @(negedge clk);
    model = model + 48'h002000000000;
    check48("R8 first of pair", acc_q, model);
    check1("R8 first of pair", done, 1'b1);
    drive(32'h00C00000, 32'h00000001, 1'b1, 1'b1, 1'b1);
    @(negedge clk);
    start = 1'b0;
    model = model - 48'h000000000002;
    check48("R8 second of pair", acc_q, model);
    check1("R8 second of pair", done, 1'b1);
    @(negedge clk);
    check1("R8 done falls", done, 1'b0);

    // R5: wrap modulo 2^48 by subtracting past zero after reset
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check48("R10 re-reset", acc_q, 48'h0);
    drive(32'h40000000, 32'hC0000000, 1'b0, 1'b0, 1'b1);
    @(negedge clk);
    start = 1'b0;
    check48("R5 wrap below zero", acc_q, 48'hFFE000000000);

    @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule